// File: doc/BRIEF.md
# Power Domain Sequencing Controller

This block takes one switchable power domain through power-down and power-up. It coordinates three parties: the interconnect port that has to be put into idle, the power switch, and an engine that saves and restores the domain's QoS context. A single command pin, qualified by a valid pin, asks for the domain to be on or off. The block compares the request with the domain's present state, which it reads from the status pins. If the two differ, it runs the matching sequence and holds `busy` high until the sequence finishes.

On power-down the interconnect port is brought to idle before the switch is opened. On power-up the switch is closed before the port leaves idle. Every wait on the interconnect or the switch is bounded by a timeout that is set in clock cycles. On expiry the block flags an error and returns to rest, leaving its request outputs as they were. Two build-time variants cover domains without a power switch (idle-only) and domains without an idle handshake. At least one of `HAS_SWITCH` and `HAS_IDLE_REQ` must be 1.

All pins are plain control and status levels or one-cycle strobes. Nothing here is a data stream, so there is no back-pressure. A command that arrives while the block is busy is dropped. It is not queued or stalled.

Top module: `pdseq_ctrl`

## Requirements
- R1: For an off command, the order is: `save_start` pulses; after `save_done`, `idle_req` rises; after `idle_ack` reads 1, the block waits for `idle_stat` to read 1; only then does `pwr_req` rise (1 requests power off). The sequence ends once `pwr_stat` reads 1.
- R2: For an on command, the order is: `pwr_req` falls; once `pwr_stat` reads 0, `idle_req` falls; once `idle_ack` and then `idle_stat` read 0, `restore_start` pulses. The sequence ends on `restore_done`.
- R3: `pwr_stat` = 1 means the domain is off and 0 means it is on. With a switch present, this bit alone gives the domain state used to judge commands.
- R4: With `HAS_SWITCH` = 0, `pwr_req` stays 0, the switch steps are skipped, and the domain counts as on exactly when `idle_stat` is 0.
- R5: With `HAS_IDLE_REQ` = 0, `idle_req` stays 0 and the handshake steps are skipped, as if they had been acknowledged.
- R6: A command whose value (`cmd_on`: 1 = on, 0 = off) equals the present domain state is ignored. `busy` does not rise and no output changes.
- R7: If a wait on `idle_ack`, `idle_stat` or `pwr_stat` lasts `TIMEOUT_CYC` cycles, `timeout_err` rises on the next edge and `busy` falls. `idle_req` and `pwr_req` keep their values at that point.
- R8: `clk_en` is 1 in every cycle of a transition, including those carrying the save and restore strobes, and 0 otherwise.
- R9: `busy` is 1 from the cycle after a command is accepted until the sequence ends. Commands that arrive while `busy` is 1 are dropped.
- R10: `timeout_err` stays set until the next accepted command clears it.
- R11: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_on | input | 1 | Requested state: 1 on, 0 off |
| idle_ack | input | 1 | Interconnect acknowledge of the idle request |
| idle_stat | input | 1 | Interconnect port reports idle |
| pwr_stat | input | 1 | Switch status: 1 off, 0 on |
| save_done | input | 1 | Context save finished (strobe) |
| restore_done | input | 1 | Context restore finished (strobe) |
| idle_req | output | 1 | Idle request to the interconnect port |
| pwr_req | output | 1 | Power-off request to the switch |
| save_start | output | 1 | One-cycle strobe starting a context save |
| restore_start | output | 1 | One-cycle strobe starting a context restore |
| clk_en | output | 1 | Domain clock enable during a transition |
| busy | output | 1 | Sequence in progress |
| timeout_err | output | 1 | A wait exceeded the timeout |

## Verification
The hardest situation to reach from the ports is a timeout in the middle of a sequence, followed by recovery from the partial state it leaves. In that state `idle_req` is still held while the domain is on, or power is still requested off while the switch has not moved. The bench drives the interconnect and switch models with freeze controls that stop the acknowledge or the switch status from following the request. This forces a timeout at a known wait, and the bench checks its length to the exact cycle. The bench then releases the freeze, lets the models settle, and issues further commands that must run correctly from that partial state.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE      = 4'd0,
    ST_SAVE      = 4'd1,
    ST_IDLE_ACK  = 4'd2,
    ST_IDLE_STAT = 4'd3,
    ST_PWR_OFF   = 4'd4,
    ST_PWR_ON    = 4'd5,
    ST_REL_ACK   = 4'd6,
    ST_REL_STAT  = 4'd7,
    ST_RESTORE   = 4'd8
  } pdseq_state_e;

  // States whose wait is bounded by the timeout counter
  function automatic logic is_timed_wait(pdseq_state_e s);
    return (s == ST_IDLE_ACK) || (s == ST_IDLE_STAT) || (s == ST_PWR_OFF) ||
           (s == ST_PWR_ON)   || (s == ST_REL_ACK)   || (s == ST_REL_STAT);
  endfunction

endpackage

// File: rtl/pdseq_status_view.sv
module pdseq_status_view #(
  parameter bit HAS_SWITCH = 1'b1
) (
  input  logic pwr_stat,
  input  logic idle_stat,
  output logic dom_on
);
  // Switch status: 1 = off. Idle-only domain: on while port not idle.
  assign dom_on = HAS_SWITCH ? ~pwr_stat : ~idle_stat;
endmodule

// File: rtl/pdseq_wait_timer.sv
module pdseq_wait_timer #(
  parameter int unsigned LIMIT = 1_250_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic expired
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr || !run) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && (cnt_q == LAST);
endmodule

// File: rtl/pdseq_fsm.sv
module pdseq_fsm
  import pdseq_pkg::*;
#(
  parameter bit HAS_SWITCH   = 1'b1,
  parameter bit HAS_IDLE_REQ = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  input  logic         cmd_on,
  input  logic         dom_on,
  input  logic         idle_ack,
  input  logic         idle_stat,
  input  logic         pwr_stat,
  input  logic         save_done,
  input  logic         restore_done,
  input  logic         tmo,
  output pdseq_state_e st_q,
  output logic         st_change,
  output logic         idle_req_q,
  output logic         pwr_req_q,
  output logic         save_start_q,
  output logic         restore_start_q,
  output logic         clk_en_q,
  output logic         err_q
);
  localparam pdseq_state_e UP_FIRST   = HAS_SWITCH   ? ST_PWR_ON  : ST_REL_ACK;
  localparam pdseq_state_e AFTER_SAVE = HAS_IDLE_REQ ? ST_IDLE_ACK : ST_PWR_OFF;
  localparam pdseq_state_e AFTER_IDLE = HAS_SWITCH   ? ST_PWR_OFF : ST_IDLE;
  localparam pdseq_state_e AFTER_PWR  = HAS_IDLE_REQ ? ST_REL_ACK : ST_RESTORE;

  pdseq_state_e st_d;
  logic         hit_tmo;
  logic         accept;

  always_comb begin
    st_d    = st_q;
    hit_tmo = 1'b0;
    unique case (st_q)
      ST_IDLE:
        if (cmd_valid && (cmd_on != dom_on)) st_d = cmd_on ? UP_FIRST : ST_SAVE;
      ST_SAVE:
        if (save_done) st_d = AFTER_SAVE;
      ST_IDLE_ACK:
        if (idle_ack)      st_d = ST_IDLE_STAT;
        else if (tmo)      begin st_d = ST_IDLE; hit_tmo = 1'b1; end
      ST_IDLE_STAT:
        if (idle_stat)     st_d = AFTER_IDLE;
        else if (tmo)      begin st_d = ST_IDLE; hit_tmo = 1'b1; end
      ST_PWR_OFF:
        if (pwr_stat)      st_d = ST_IDLE;
        else if (tmo)      begin st_d = ST_IDLE; hit_tmo = 1'b1; end
      ST_PWR_ON:
        if (!pwr_stat)     st_d = AFTER_PWR;
        else if (tmo)      begin st_d = ST_IDLE; hit_tmo = 1'b1; end
      ST_REL_ACK:
        if (!idle_ack)     st_d = ST_REL_STAT;
        else if (tmo)      begin st_d = ST_IDLE; hit_tmo = 1'b1; end
      ST_REL_STAT:
        if (!idle_stat)    st_d = ST_RESTORE;
        else if (tmo)      begin st_d = ST_IDLE; hit_tmo = 1'b1; end
      ST_RESTORE:
        if (restore_done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign st_change = (st_d != st_q);
  assign accept    = (st_q == ST_IDLE) && (st_d != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q            <= ST_IDLE;
      idle_req_q      <= 1'b0;
      pwr_req_q       <= 1'b0;
      save_start_q    <= 1'b0;
      restore_start_q <= 1'b0;
      clk_en_q        <= 1'b0;
      err_q           <= 1'b0;
    end else begin
      st_q            <= st_d;
      save_start_q    <= (st_d == ST_SAVE)    && (st_q != ST_SAVE);
      restore_start_q <= (st_d == ST_RESTORE) && (st_q != ST_RESTORE);
      clk_en_q        <= (st_d != ST_IDLE);
      if ((st_d == ST_IDLE_ACK) && (st_q != ST_IDLE_ACK))     idle_req_q <= 1'b1;
      else if ((st_d == ST_REL_ACK) && (st_q != ST_REL_ACK))  idle_req_q <= 1'b0;
      if ((st_d == ST_PWR_OFF) && (st_q != ST_PWR_OFF))       pwr_req_q  <= 1'b1;
      else if ((st_d == ST_PWR_ON) && (st_q != ST_PWR_ON))    pwr_req_q  <= 1'b0;
      if (hit_tmo)     err_q <= 1'b1;
      else if (accept) err_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pdseq_ctrl.sv
module pdseq_ctrl
  import pdseq_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC  = 1_250_000,
  parameter bit          HAS_SWITCH   = 1'b1,
  parameter bit          HAS_IDLE_REQ = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic cmd_on,
  input  logic idle_ack,
  input  logic idle_stat,
  input  logic pwr_stat,
  input  logic save_done,
  input  logic restore_done,
  output logic idle_req,
  output logic pwr_req,
  output logic save_start,
  output logic restore_start,
  output logic clk_en,
  output logic busy,
  output logic timeout_err
);
  pdseq_state_e st;
  logic         st_change;
  logic         dom_on;
  logic         tmo;

  pdseq_status_view #(.HAS_SWITCH(HAS_SWITCH)) u_view (
    .pwr_stat (pwr_stat),
    .idle_stat(idle_stat),
    .dom_on   (dom_on)
  );

  pdseq_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (is_timed_wait(st)),
    .clr    (st_change),
    .expired(tmo)
  );

  pdseq_fsm #(.HAS_SWITCH(HAS_SWITCH), .HAS_IDLE_REQ(HAS_IDLE_REQ)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_valid      (cmd_valid),
    .cmd_on         (cmd_on),
    .dom_on         (dom_on),
    .idle_ack       (idle_ack),
    .idle_stat      (idle_stat),
    .pwr_stat       (pwr_stat),
    .save_done      (save_done),
    .restore_done   (restore_done),
    .tmo            (tmo),
    .st_q           (st),
    .st_change      (st_change),
    .idle_req_q     (idle_req),
    .pwr_req_q      (pwr_req),
    .save_start_q   (save_start),
    .restore_start_q(restore_start),
    .clk_en_q       (clk_en),
    .err_q          (timeout_err)
  );

  assign busy = (st != ST_IDLE);
endmodule

// File: rtl/pdseq_ctrl_chk.sv
module pdseq_ctrl_chk #(
  parameter bit HAS_SWITCH   = 1'b1,
  parameter bit HAS_IDLE_REQ = 1'b1
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_on,
  input logic idle_ack,
  input logic idle_stat,
  input logic pwr_stat,
  input logic idle_req,
  input logic pwr_req,
  input logic save_start,
  input logic restore_start,
  input logic clk_en,
  input logic busy,
  input logic timeout_err
);
  logic seen_on;
  assign seen_on = HAS_SWITCH ? !pwr_stat : !idle_stat;

  a_r1_off_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_req) |-> (!HAS_IDLE_REQ || (idle_req && $past(idle_stat))));

  a_r2_release_after_on: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idle_req) |-> (!pwr_req && (!HAS_SWITCH || $past(!pwr_stat))));

  a_r2_restore_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(restore_start) |-> (!idle_req && $past(!idle_stat || !HAS_IDLE_REQ)));

  a_r4_no_switch_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !HAS_SWITCH |-> !pwr_req);

  a_r5_no_handshake_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !HAS_IDLE_REQ |-> !idle_req);

  a_r6_match_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && (cmd_on == seen_on)) |=> !busy);

  a_r7_err_at_rest: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> !busy);

  a_r8_clk_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (save_start || restore_start) |-> (clk_en && busy));

  a_r9_save_single: assert property (@(posedge clk) disable iff (!rst_n)
    save_start |=> !save_start);
endmodule

bind pdseq_ctrl pdseq_ctrl_chk #(.HAS_SWITCH(HAS_SWITCH), .HAS_IDLE_REQ(HAS_IDLE_REQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_on(cmd_on),
  .idle_ack(idle_ack), .idle_stat(idle_stat), .pwr_stat(pwr_stat),
  .idle_req(idle_req), .pwr_req(pwr_req), .save_start(save_start),
  .restore_start(restore_start), .clk_en(clk_en), .busy(busy),
  .timeout_err(timeout_err)
);

// File: tb/tb_pdseq_ctrl.sv
`timescale 1ns/1ps

module tb_pd_env (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idle_req,
  input  logic       pwr_req,
  input  logic       save_start,
  input  logic       restore_start,
  input  logic       stk_ack,
  input  logic       stk_pwr,
  input  logic [3:0] lat,
  output logic       idle_ack,
  output logic       idle_stat,
  output logic       pwr_stat,
  output logic       save_done,
  output logic       restore_done
);
  int ca, cs, cp;
  logic [1:0] sp, rp;
  assign save_done    = sp[1];
  assign restore_done = rp[1];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_ack <= 0; idle_stat <= 0; pwr_stat <= 0;
      ca <= 0; cs <= 0; cp <= 0; sp <= 0; rp <= 0;
    end else begin
      sp <= {sp[0], save_start};
      rp <= {rp[0], restore_start};
      if (idle_ack != idle_req && !stk_ack) begin
        if (ca >= int'(lat)) begin idle_ack <= idle_req; ca <= 0; end else ca <= ca + 1;
      end else ca <= 0;
      if (idle_stat != idle_ack) begin
        if (cs >= int'(lat)) begin idle_stat <= idle_ack; cs <= 0; end else cs <= cs + 1;
      end else cs <= 0;
      if (pwr_stat != pwr_req && !stk_pwr) begin
        if (cp >= int'(lat)) begin pwr_stat <= pwr_req; cp <= 0; end else cp <= cp + 1;
      end else cp <= 0;
    end
  end
endmodule

module tb_pdseq_ctrl;
  localparam int TO_CYC = 40;

  typedef struct packed {
    logic       on;
    logic [3:0] lat;
    logic       stk_ack;
    logic       stk_pwr;
    logic       e_err;
    logic       e_ireq;
    logic       e_preq;
    logic [1:0] ord;   // 1 = check off order, 2 = check on order
    logic       ign;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd1, 1'b0},
    '{1'b1, 4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0},
    '{1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd1, 1'b0},
    '{1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 1'b1},
    '{1'b1, 4'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0},
    '{1'b0, 4'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0},
    '{1'b0, 4'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0},
    '{1'b1, 4'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0},
    '{1'b0, 4'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0},
    '{1'b1, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0}
  };

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic cmd_on = 0;
  logic m_cv = 0, io_cv = 0, nh_cv = 0;
  logic stk_ack = 0, stk_pwr = 0;
  logic [3:0] lat = 4'd1;

  logic m_ack, m_ist, m_pst, m_sd, m_rd, m_ireq, m_preq, m_ss, m_rs, m_ce, m_busy, m_err;
  logic i_ack, i_ist, i_pst, i_sd, i_rd, i_ireq, i_preq, i_ss, i_rs, i_ce, i_busy, i_err;
  logic n_ack, n_ist, n_pst, n_sd, n_rd, n_ireq, n_preq, n_ss, n_rs, n_ce, n_busy, n_err;

  pdseq_ctrl #(.TIMEOUT_CYC(TO_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(m_cv), .cmd_on(cmd_on),
    .idle_ack(m_ack), .idle_stat(m_ist), .pwr_stat(m_pst), .save_done(m_sd),
    .restore_done(m_rd), .idle_req(m_ireq), .pwr_req(m_preq), .save_start(m_ss),
    .restore_start(m_rs), .clk_en(m_ce), .busy(m_busy), .timeout_err(m_err));
  tb_pd_env env_m (.clk(clk), .rst_n(rst_n), .idle_req(m_ireq), .pwr_req(m_preq),
    .save_start(m_ss), .restore_start(m_rs), .stk_ack(stk_ack), .stk_pwr(stk_pwr),
    .lat(lat), .idle_ack(m_ack), .idle_stat(m_ist), .pwr_stat(m_pst),
    .save_done(m_sd), .restore_done(m_rd));

  pdseq_ctrl #(.TIMEOUT_CYC(TO_CYC), .HAS_SWITCH(1'b0)) dut_io (
    .clk(clk), .rst_n(rst_n), .cmd_valid(io_cv), .cmd_on(cmd_on),
    .idle_ack(i_ack), .idle_stat(i_ist), .pwr_stat(i_pst), .save_done(i_sd),
    .restore_done(i_rd), .idle_req(i_ireq), .pwr_req(i_preq), .save_start(i_ss),
    .restore_start(i_rs), .clk_en(i_ce), .busy(i_busy), .timeout_err(i_err));
  tb_pd_env env_io (.clk(clk), .rst_n(rst_n), .idle_req(i_ireq), .pwr_req(i_preq),
    .save_start(i_ss), .restore_start(i_rs), .stk_ack(1'b0), .stk_pwr(1'b0),
    .lat(4'd1), .idle_ack(i_ack), .idle_stat(i_ist), .pwr_stat(i_pst),
    .save_done(i_sd), .restore_done(i_rd));

  pdseq_ctrl #(.TIMEOUT_CYC(TO_CYC), .HAS_IDLE_REQ(1'b0)) dut_nh (
    .clk(clk), .rst_n(rst_n), .cmd_valid(nh_cv), .cmd_on(cmd_on),
    .idle_ack(n_ack), .idle_stat(n_ist), .pwr_stat(n_pst), .save_done(n_sd),
    .restore_done(n_rd), .idle_req(n_ireq), .pwr_req(n_preq), .save_start(n_ss),
    .restore_start(n_rs), .clk_en(n_ce), .busy(n_busy), .timeout_err(n_err));
  tb_pd_env env_nh (.clk(clk), .rst_n(rst_n), .idle_req(n_ireq), .pwr_req(n_preq),
    .save_start(n_ss), .restore_start(n_rs), .stk_ack(1'b0), .stk_pwr(1'b0),
    .lat(4'd1), .idle_ack(n_ack), .idle_stat(n_ist), .pwr_stat(n_pst),
    .save_done(n_sd), .restore_done(n_rd));

  // ---------------- event monitor (negedge sampling) ----------------
  int cyc = 0;
  always @(posedge clk) cyc = cyc + 1;

  int t_cmd, t_save, t_rest, t_ireq_r, t_ireq_f, t_preq_r, t_preq_f;
  int t_ist_r, t_ist_f, t_pst_r, t_pst_f, t_busy_r, t_busy_f, t_err_r;
  int clk_bad = 0, io_save = 0, io_rest = 0, io_brise = 0, nh_save = 0, nh_rest = 0, nh_brise = 0;
  logic p_ireq = 0, p_preq = 0, p_ist = 0, p_pst = 0, p_busy = 0, p_err = 0, pi_busy = 0, pn_busy = 0;

  always @(negedge clk) begin
    if (m_ss) t_save = cyc;
    if (m_rs) t_rest = cyc;
    if (m_ireq && !p_ireq) t_ireq_r = cyc;
    if (!m_ireq && p_ireq) t_ireq_f = cyc;
    if (m_preq && !p_preq) t_preq_r = cyc;
    if (!m_preq && p_preq) t_preq_f = cyc;
    if (m_ist && !p_ist) t_ist_r = cyc;
    if (!m_ist && p_ist) t_ist_f = cyc;
    if (m_pst && !p_pst) t_pst_r = cyc;
    if (!m_pst && p_pst) t_pst_f = cyc;
    if (m_busy && !p_busy) t_busy_r = cyc;
    if (!m_busy && p_busy) t_busy_f = cyc;
    if (m_err && !p_err) t_err_r = cyc;
    if (rst_n && (m_ce != m_busy || i_ce != i_busy || n_ce != n_busy)) clk_bad++;
    if (i_ss) io_save++;
    if (i_rs) io_rest++;
    if (i_busy && !pi_busy) io_brise++;
    if (n_ss) nh_save++;
    if (n_rs) nh_rest++;
    if (n_busy && !pn_busy) nh_brise++;
    p_ireq = m_ireq; p_preq = m_preq; p_ist = m_ist; p_pst = m_pst;
    p_busy = m_busy; p_err = m_err; pi_busy = i_busy; pn_busy = n_busy;
  end

  // ---------------- checking ----------------
  int n_run = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(input int which, input logic on);
    @(negedge clk);
    cmd_on = on;
    if (which == 0) m_cv = 1; else if (which == 1) io_cv = 1; else nh_cv = 1;
    t_cmd = cyc;
    @(negedge clk);
    m_cv = 0; io_cv = 0; nh_cv = 0;
  endtask

  task automatic settle();
    for (int i = 0; i < 400 && (m_busy || i_busy || n_busy); i++) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11: reset state
    chk("R11 idle_req", m_ireq, 0);
    chk("R11 pwr_req", m_preq, 0);
    chk("R11 strobes", m_ss | m_rs, 0);
    chk("R11 busy/clk_en/err", m_busy | m_ce | m_err, 0);

    for (int v = 0; v < NV; v++) begin
      stk_ack = VEC[v].stk_ack;
      stk_pwr = VEC[v].stk_pwr;
      lat     = VEC[v].lat;
      repeat (10) @(negedge clk);
      pulse(0, VEC[v].on);
      settle();
      chk($sformatf("R7/R10 err vec%0d", v), m_err, VEC[v].e_err);
      chk($sformatf("R1/R2/R7 idle_req vec%0d", v), m_ireq, VEC[v].e_ireq);
      chk($sformatf("R1/R2/R7 pwr_req vec%0d", v), m_preq, VEC[v].e_preq);
      chk($sformatf("R9 busy low vec%0d", v), m_busy, 0);
      chk($sformatf("R8 clk_en tracks transition vec%0d", v), clk_bad, 0);
      if (VEC[v].ign)
        chk($sformatf("R6 matching cmd ignored vec%0d", v), int'(t_busy_r < t_cmd), 1);
      if (VEC[v].ord == 2'd1) begin
        chk("R1 save after cmd", int'(t_save > t_cmd), 1);
        chk("R1 idle_req after save", int'(t_ireq_r > t_save), 1);
        chk("R1 pwr_req after idle status", int'(t_preq_r > t_ist_r && t_ist_r > t_ireq_r), 1);
        chk("R3 done only after status reads 1 (off)", int'(t_busy_f > t_pst_r && m_pst), 1);
      end
      if (VEC[v].ord == 2'd2) begin
        chk("R2 pwr_req falls first", int'(t_preq_f > t_cmd), 1);
        chk("R2 idle release after status reads 0 (on)", int'(t_ireq_f > t_pst_f && t_pst_f > t_preq_f), 1);
        chk("R2 restore after idle status clears", int'(t_rest > t_ist_f && t_ist_f > t_ireq_f), 1);
      end
      if (VEC[v].e_err)
        chk($sformatf("R7 timeout length vec%0d", v),
            VEC[v].stk_ack ? (t_err_r - t_ireq_r) : (t_err_r - t_preq_f), TO_CYC);
    end
    stk_ack = 0; stk_pwr = 0; lat = 4'd1;

    // R9: command during busy is dropped (domain is on here)
    repeat (5) @(negedge clk);
    pulse(0, 1'b0);
    repeat (2) @(negedge clk);
    chk("R9 busy during transition", m_busy, 1);
    pulse(0, 1'b1);
    settle();
    repeat (10) @(negedge clk);
    chk("R9 dropped cmd left domain off", m_preq, 1);
    chk("R9 no second transition", int'(t_busy_r < t_busy_f), 1);
    pulse(0, 1'b1);
    settle();
    chk("R2 back on", m_preq | m_ireq, 0);

    // R4: idle-only variant
    pulse(1, 1'b0);
    settle();
    chk("R4 idle-only off: idle_req", i_ireq, 1);
    chk("R4 idle-only off: pwr_req stays 0", i_preq, 0);
    chk("R4 idle-only save strobes", io_save, 1);
    pulse(1, 1'b0);
    settle();
    chk("R4 idle-only off state from idle status (ignored)", io_brise, 1);
    pulse(1, 1'b1);
    settle();
    chk("R4 idle-only on: idle_req", i_ireq, 0);
    chk("R4 idle-only restore strobes", io_rest, 1);
    chk("R4 idle-only pwr_req", i_preq, 0);

    // R5: no-handshake variant
    pulse(2, 1'b0);
    settle();
    chk("R5 no-handshake off: pwr_req", n_preq, 1);
    chk("R5 no-handshake idle_req stays 0", n_ireq, 0);
    chk("R5 no-handshake save strobes", nh_save, 1);
    pulse(2, 1'b1);
    settle();
    chk("R5 no-handshake on: pwr_req", n_preq, 0);
    chk("R5 no-handshake restore strobes", nh_rest, 1);
    chk("R5 no-handshake err", n_err | i_err, 0);
    chk("R8 clk_en overall", clk_bad, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule